// File: doc/BRIEF.md
# Latency-Emulating Memory Request Router

This block sits between one processor core and the memories behind it. Each core request is steered by its address to one of three downstream ports: a private main-memory port, a shared main-memory port, or the cached path through the L1 caches. The core then sees a response after exactly the latency configured for the memory type that served it, whatever the real memory did. If the real memory is faster, the block holds the data back until the configured cycle count has elapsed. If the real memory is slower, the block raises a stop request for the core's virtual clock. The core keeps its state while frozen and resumes once the data is present.

The block and its memories run on the memory-side clock `clk`. The core runs on a separate virtual clock, which a clock manager outside this block gates with `vclk_stop`. Only one request is in flight at a time.

The controller has five states, with these transitions:

- IDLE accepts a request and goes to ISSUE when the address hits a region, or to ERR when it hits none.
- ISSUE presents the request downstream and moves to WAIT on the port's ready.
- WAIT moves to HOLD when the port's response arrives.
- HOLD returns to IDLE once the latency target is reached, and delivers the response in that cycle.
- ERR delivers an error response and returns to IDLE.

Top module: `mem_latency_router`

## Requirements
- R1: An address with `cfg_priv_base <= addr <= cfg_priv_limit` is private and is checked first. One with `cfg_shr_base <= addr <= cfg_shr_limit` is shared. A noncacheable private request goes to port index 0 and a noncacheable shared one to index 1, with at most one `mem_req_valid` bit high, held until accepted.
- R2: A private or shared request whose cacheable flag (`cfg_priv_cacheable` / `cfg_shr_cacheable`) is set goes to the cached path, port index 2, and is timed with `cfg_lat_cache`.
- R3: When the memory answers early, `rsp_valid` rises exactly L cycles after the cycle in which the request was accepted, where L (at least 1) is the latency of the chosen memory type. Its 16-bit counter starts at acceptance.
- R4: When the memory answers late, `vclk_stop` is high from the cycle in which L has elapsed until the memory's response arrives. `rsp_valid` follows in the next cycle, in the same cycle that `vclk_stop` falls.
- R5: `vclk_stop` and `rsp_valid` are never high in the same cycle.
- R6: An address in no region gives `rsp_valid` with `rsp_err` = 1 one cycle after acceptance. It issues no memory request and never raises `vclk_stop`.
- R7: `req_ready` falls after an acceptance and returns only in the cycle after `rsp_valid`.
- R8: `rsp_rdata` carries the data returned by the selected port.
- R9: Each memory type has its own latency counter and target, so different types yield their own latencies.
- R10: During and after reset, `req_ready` = 1 and `rsp_valid`, `vclk_stop` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | AW | Request address |
| req_we | input | 1 | Write request |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response to the core (one cycle) |
| rsp_err | output | 1 | Response is an unmapped-address error |
| rsp_rdata | output | DW | Response data |
| vclk_stop | output | 1 | Request to freeze the core's virtual clock |
| cfg_priv_base | input | AW | Private region lowest address |
| cfg_priv_limit | input | AW | Private region highest address |
| cfg_shr_base | input | AW | Shared region lowest address |
| cfg_shr_limit | input | AW | Shared region highest address |
| cfg_priv_cacheable | input | 1 | Route private region through caches |
| cfg_shr_cacheable | input | 1 | Route shared region through caches |
| cfg_lat_priv | input | LW | Target latency, private memory |
| cfg_lat_shr | input | LW | Target latency, shared memory |
| cfg_lat_cache | input | LW | Target latency, cached path |
| mem_req_valid | output | 3 | Per-port request valid (0 private, 1 shared, 2 cache) |
| mem_req_ready | input | 3 | Per-port request ready |
| mem_addr | output | AW | Forwarded address |
| mem_we | output | 1 | Forwarded write flag |
| mem_wdata | output | DW | Forwarded write data |
| mem_rsp_valid | input | 3 | Per-port response valid |
| mem_rsp_data | input | 3*DW | Per-port response data, port i at bits i*DW |

## Verification
The hardest case to reach is the boundary where the memory's data arrives in exactly the cycle the latency target expires. Here the block must neither raise the clock stop for one spurious cycle nor deliver the data a cycle early. The bench gets there with a memory model whose response delay is set per request, and chooses that delay as two less than the target. It also sweeps delays on both sides of that point. For each request the scoreboard predicts the response cycle and the exact number of stop cycles from the acceptance cycle, the delay and the target.

// File: rtl/mlr_pkg.sv
package mlr_pkg;
    localparam int NPORT = 3;

    typedef enum logic [1:0] {
        PORT_PRIV  = 2'd0,
        PORT_SHR   = 2'd1,
        PORT_CACHE = 2'd2
    } port_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_HOLD,
        ST_ERR
    } state_e;
endpackage

// File: rtl/mlr_region_decoder.sv
module mlr_region_decoder
    import mlr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] priv_base,
    input  logic [AW-1:0] priv_limit,
    input  logic [AW-1:0] shr_base,
    input  logic [AW-1:0] shr_limit,
    input  logic          priv_cacheable,
    input  logic          shr_cacheable,
    output logic          hit,
    output port_e         port
);
    logic in_priv, in_shr;

    assign in_priv = (addr >= priv_base) && (addr <= priv_limit);
    assign in_shr  = (addr >= shr_base)  && (addr <= shr_limit);

    always_comb begin
        hit  = 1'b1;
        port = PORT_PRIV;
        if (in_priv) begin
            port = priv_cacheable ? PORT_CACHE : PORT_PRIV;
        end else if (in_shr) begin
            port = shr_cacheable ? PORT_CACHE : PORT_SHR;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/mlr_lat_counter.sv
module mlr_lat_counter #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [LW-1:0] target,
    output logic          reached
);
    localparam logic [LW-1:0] CNT_MAX = {LW{1'b1}};

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LW'(1);
        end else if (run && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end

    assign reached = (cnt_q >= target);
endmodule

// File: rtl/mem_latency_router.sv
module mem_latency_router
    import mlr_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [AW-1:0]       req_addr,
    input  logic                req_we,
    input  logic [DW-1:0]       req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DW-1:0]       rsp_rdata,
    output logic                vclk_stop,
    input  logic [AW-1:0]       cfg_priv_base,
    input  logic [AW-1:0]       cfg_priv_limit,
    input  logic [AW-1:0]       cfg_shr_base,
    input  logic [AW-1:0]       cfg_shr_limit,
    input  logic                cfg_priv_cacheable,
    input  logic                cfg_shr_cacheable,
    input  logic [LW-1:0]       cfg_lat_priv,
    input  logic [LW-1:0]       cfg_lat_shr,
    input  logic [LW-1:0]       cfg_lat_cache,
    output logic [NPORT-1:0]    mem_req_valid,
    input  logic [NPORT-1:0]    mem_req_ready,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_we,
    output logic [DW-1:0]       mem_wdata,
    input  logic [NPORT-1:0]    mem_rsp_valid,
    input  logic [NPORT*DW-1:0] mem_rsp_data
);
    state_e        state_q, state_d;
    port_e         sel_q, dec_port;
    logic          dec_hit;
    logic          accept;
    logic          busy;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [DW-1:0] wdata_q, data_q;
    logic [NPORT-1:0] reached;
    logic          reached_sel, port_ready, port_rsp;
    logic [DW-1:0] port_data;
    logic [LW-1:0] lat_tgt [NPORT];

    assign lat_tgt[0] = cfg_lat_priv;
    assign lat_tgt[1] = cfg_lat_shr;
    assign lat_tgt[2] = cfg_lat_cache;

    mlr_region_decoder #(.AW(AW)) u_dec (
        .addr           (req_addr),
        .priv_base      (cfg_priv_base),
        .priv_limit     (cfg_priv_limit),
        .shr_base       (cfg_shr_base),
        .shr_limit      (cfg_shr_limit),
        .priv_cacheable (cfg_priv_cacheable),
        .shr_cacheable  (cfg_shr_cacheable),
        .hit            (dec_hit),
        .port           (dec_port)
    );

    assign accept = req_valid && req_ready;
    assign busy   = (state_q != ST_IDLE);

    for (genvar g = 0; g < NPORT; g++) begin : g_cnt
        mlr_lat_counter #(.LW(LW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (accept && dec_hit && dec_port == port_e'(g)),
            .run     (busy && sel_q == port_e'(g)),
            .target  (lat_tgt[g]),
            .reached (reached[g])
        );
    end

    always_comb begin
        reached_sel = 1'b0;
        port_ready  = 1'b0;
        port_rsp    = 1'b0;
        port_data   = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (sel_q == port_e'(i)) begin
                reached_sel = reached[i];
                port_ready  = mem_req_ready[i];
                port_rsp    = mem_rsp_valid[i];
                port_data   = mem_rsp_data[i*DW +: DW];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = dec_hit ? ST_ISSUE : ST_ERR;
            ST_ISSUE: if (port_ready) state_d = ST_WAIT;
            ST_WAIT:  if (port_rsp) state_d = ST_HOLD;
            ST_HOLD:  if (reached_sel) state_d = ST_IDLE;
            ST_ERR:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= PORT_PRIV;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            data_q  <= '0;
        end else begin
            if (accept) begin
                sel_q   <= dec_port;
                addr_q  <= req_addr;
                we_q    <= req_we;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_WAIT && port_rsp) data_q <= port_data;
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        rsp_err       = 1'b0;
        vclk_stop     = 1'b0;
        mem_req_valid = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                mem_req_valid[sel_q] = 1'b1;
                vclk_stop = reached_sel;
            end
            ST_WAIT:  vclk_stop = reached_sel;
            ST_HOLD:  rsp_valid = reached_sel;
            ST_ERR: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    assign rsp_rdata = rsp_err ? '0 : data_q;
    assign mem_addr  = addr_q;
    assign mem_we    = we_q;
    assign mem_wdata = wdata_q;

    // R1
    mem_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_req_valid));
    // R1
    issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mem_req_valid) && !(|(mem_req_valid & mem_req_ready)))
        |=> ($stable(mem_req_valid) && $stable(mem_addr)));
    // R4
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vclk_stop) |-> rsp_valid);
    // R5
    stop_rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vclk_stop |-> !rsp_valid);
    // R6
    err_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($past(req_valid && req_ready) && !vclk_stop));
    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7
    free_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);
endmodule

// File: tb/mem_latency_router_tb.sv
module mem_latency_router_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err, vclk_stop, mem_we;
    logic [DW-1:0] rsp_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic [AW-1:0] priv_base = 32'h0000_0000, priv_limit = 32'h0000_FFFF;
    logic [AW-1:0] shr_base = 32'h1000_0000, shr_limit = 32'h1000_FFFF;
    logic priv_cach = 1'b0, shr_cach = 1'b0;
    logic [LW-1:0] lat_p = 16'd5, lat_s = 16'd8, lat_c = 16'd4;
    logic [2:0] mem_req_valid, mem_rsp_valid = '0;
    logic [2:0] mem_req_ready = 3'b111;
    logic [3*DW-1:0] mem_rsp_data;
    logic [AW-1:0] madr [3];
    int tmr [3];
    int dly [3];

    mem_latency_router #(.AW(AW), .DW(DW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .vclk_stop(vclk_stop),
        .cfg_priv_base(priv_base), .cfg_priv_limit(priv_limit),
        .cfg_shr_base(shr_base), .cfg_shr_limit(shr_limit),
        .cfg_priv_cacheable(priv_cach), .cfg_shr_cacheable(shr_cach),
        .cfg_lat_priv(lat_p), .cfg_lat_shr(lat_s), .cfg_lat_cache(lat_c),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    for (genvar g = 0; g < 3; g++) begin : g_mdata
        assign mem_rsp_data[g*DW +: DW] = madr[g] ^ (32'hA5A5_0000 + g);
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [31:0] data;
        bit          err;
        int          stops;
        int          port;
        string       tag;
    } item_t;
    item_t sb[$];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // memory model: one response per request, after dly cycles
    initial begin
        for (int i = 0; i < 3; i++) begin
            tmr[i] = 0; dly[i] = 1; madr[i] = '0;
        end
        forever begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                mem_rsp_valid[i] = 1'b0;
                if (tmr[i] > 0) begin
                    tmr[i]--;
                    if (tmr[i] == 0) mem_rsp_valid[i] = 1'b1;
                end
                if (mem_req_valid[i] && mem_req_ready[i]) begin
                    tmr[i] = dly[i];
                    madr[i] = mem_addr;
                end
            end
        end
    end

    // monitor
    int stop_cnt = 0;
    int seen_port = -1;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (vclk_stop) stop_cnt++;
                for (int i = 0; i < 3; i++) if (mem_req_valid[i]) seen_port = i;
                if (rsp_valid) begin
                    if (sb.size() == 0) begin
                        chk(0, "R7", "unexpected response", 1, 0);
                    end else begin
                        item_t e;
                        e = sb.pop_front();
                        chk(cyc == e.at, e.tag, "response cycle", cyc, e.at);
                        chk(rsp_err == e.err, e.tag, "error flag", rsp_err, e.err);
                        if (!e.err) chk(rsp_rdata == e.data, "R8", "data", rsp_rdata, e.data);
                        chk(stop_cnt == e.stops, e.tag, "stop cycles", stop_cnt, e.stops);
                        chk(seen_port == e.port, e.tag, "port", seen_port, e.port);
                    end
                    stop_cnt = 0;
                    seen_port = -1;
                end
            end
        end
    end

    // driver
    task automatic drive(logic [31:0] a, int port, int lat, int d, bit err, string tag);
        item_t e;
        int acc;
        @(negedge clk);
        if (port >= 0) dly[port] = d;
        req_addr  = a;
        req_valid = 1'b1;
        req_wdata = a + 1;
        @(posedge clk);
        #1;
        acc = cyc;
        req_valid = 1'b0;
        e.tag  = tag;
        e.err  = err;
        e.port = port;
        e.data = a ^ (32'hA5A5_0000 + port);
        if (err) begin
            e.at = acc;
            e.stops = 0;
        end else begin
            e.at = (acc - 1 + lat > acc + d + 1) ? acc - 1 + lat : acc + d + 1;
            e.stops = (d - lat + 2 > 0) ? d - lat + 2 : 0;
        end
        sb.push_back(e);
        @(negedge clk);
        if (e.at > cyc) chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
        wait (sb.size() == 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R7", "ready after response", req_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0 && vclk_stop == 1'b0, "R10", "rsp/stop", {rsp_valid, vclk_stop}, 0);
        chk(mem_req_valid == 3'b000, "R10", "mem_req_valid", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 0, "R10", "after reset", req_ready, 1);

        drive(32'h0000_0100, 0, 5, 1, 0, "R3");          // R3 R1 fast private
        drive(32'h0000_0200, 0, 5, 9, 0, "R4");          // R4 slow private
        drive(32'h1000_0040, 1, 8, 2, 0, "R9");          // R9 R3 fast shared
        lat_s = 16'd2;
        drive(32'h1000_FFFF, 1, 2, 4, 0, "R4");          // R4 R1 shared upper bound
        drive(32'h0000_0000, 0, 5, 3, 0, "R5");          // R5 arrival exactly at target
        drive(32'h0000_1000, 0, 5, 4, 0, "R5");          // R5 one cycle late
        priv_cach = 1'b1;
        drive(32'h0000_0300, 2, 4, 1, 0, "R2");          // R2 private through caches
        drive(32'h0000_0304, 2, 4, 7, 0, "R2");          // R2 cached path stall
        priv_cach = 1'b0;
        shr_cach = 1'b1;
        drive(32'h1000_0000, 2, 4, 2, 0, "R2");          // R2 shared through caches
        shr_cach = 1'b0;
        drive(32'h2000_0000, -1, 0, 0, 1, "R6");         // R6 unmapped address
        drive(32'h1001_0000, -1, 0, 0, 1, "R6");         // R6 just above shared limit
        lat_p = 16'd1;
        drive(32'h0000_0400, 0, 1, 1, 0, "R3");          // R3 minimum latency

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule